// File: doc/BRIEF.md
# Audio Master Clock and Frame Divider

This block turns a fast audio reference clock into two derived timing signals: an audio master clock obtained by integer division, and a one-cycle strobe at the audio sample rate. Two 6-bit fields set the ratios. A ratio field `div` makes the master clock the reference divided by (div+1). A frame field `fs` makes the sample-rate strobe the reference divided by 32×(fs+1), so the master clock runs at 32×(fs+1)/(div+1) times the sample rate. For example, div=7 with fs=63 gives a master clock of 256 times the sample rate, and div=0 with fs=47 gives 1536 times.

Software programs the fields and the output mode first and then issues a one-cycle enable command. The generator captures the fields and the mode at that moment and runs until a one-cycle disable command arrives. It finishes the master clock period in progress and stops in the low phase, so the output pin never sees a shortened pulse. When the output mode bit is 0, the divider and the strobe still run but the master clock pin is held low. In that mode the reference itself is routed to the bit clock elsewhere.

Top module: `mclk_frame_div`

## Requirements
- R1: With N = div+1 ≥ 2 and N even, `mclk` is high for N/2 reference cycles and low for N/2. The first high phase begins at the reference edge that accepts the enable command.
- R2: `frame_tick` is a single-cycle pulse. It first appears 32×(fs+1) reference cycles after the accepting edge and repeats with that period while the generator runs.
- R3: With N odd and N ≥ 3, `mclk` has period N and is high for exactly N reference half-cycles, starting half a reference cycle after the accepting edge. With N = 1, `mclk` carries every full high phase of the reference, starting one cycle after the accepting edge.
- R4: When the captured mode bit is 0, `mclk` stays low while `mclk_on` and `frame_tick` behave as in mode 1.
- R5: `mclk_on` rises at the edge that samples `en_cmd`=1 with `dis_cmd`=0 while the generator is idle. An enable command while running is ignored, and enable together with disable while idle does not start the generator.
- R6: A disable command sampled at relative edge d stops the generator at the first edge j ≥ d that is a multiple of N after the start. `mclk_on` falls there, and `mclk` gives no pulse after its last complete one. `frame_tick` pulses no later than edge j.
- R7: The divider field, the frame field and the mode bit are captured only when an enable command is accepted. Changes to them while running have no effect on the outputs.
- R8: A disable command while idle has no effect. The outputs stay low, and a later enable starts normally.
- R9: While reset is asserted and after it is released, `mclk`, `mclk_on` and `frame_tick` are low until an enable command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast audio reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_in | input | 6 | Master clock ratio field div (ratio div+1) |
| fs_in | input | 6 | Frame ratio field fs (frame = 32×(fs+1) reference cycles) |
| mode_in | input | 1 | 1 drives the master clock pin, 0 holds it low |
| en_cmd | input | 1 | One-cycle enable command |
| dis_cmd | input | 1 | One-cycle disable command |
| mclk | output | 1 | Audio master clock |
| mclk_on | output | 1 | High while the generator runs |
| frame_tick | output | 1 | One-cycle sample-rate strobe |

## Verification
The hardest situation to reach is a disable command arriving at a chosen phase of the divider, for odd ratios and for a ratio of one. In those cases the stop must land in a low phase while the output is formed from both reference edges. The bench sweeps every ratio from 1 to 8 with two frame sizes. For each, it places the disable at an offset that walks through the divider phases, including the exact last cycle of a period and the very first cycle after enable. It then compares the master clock at half-cycle resolution against an arithmetic model up to and past the stop edge. A separate run changes all fields and re-issues enable in the middle of operation to show that the captured settings hold.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

  // Generator run state
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } gen_state_e;

endpackage

// File: rtl/mfd_seq.sv
// Enable/disable sequencing and capture of the ratio fields.
module mfd_seq
  import mfd_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int FS_W  = 6
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             en_cmd,
  input  logic             dis_cmd,
  input  logic             wrap,
  input  logic [DIV_W-1:0] div_in,
  input  logic [FS_W-1:0]  fs_in,
  input  logic             mode_in,
  output logic             start,
  output logic             run_q,
  output logic             run_d,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_d,
  output logic [FS_W-1:0]  fs_q,
  output logic             mode_q
);

  gen_state_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_cmd && !dis_cmd) begin
          st_d  = ST_RUN;
          start = 1'b1;
        end
      end
      ST_RUN: begin
        if (dis_cmd) st_d = wrap ? ST_IDLE : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (wrap) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // Captured configuration: loaded only on an accepted enable
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      fs_q   <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      div_q  <= div_in;
      fs_q   <= fs_in;
      mode_q <= mode_in;
    end
  end

  assign div_d = start ? div_in : div_q;
  assign run_q = (st_q != ST_IDLE);
  assign run_d = (st_d != ST_IDLE);

endmodule

// File: rtl/mfd_clkdiv.sv
// Integer master clock divider with a falling-edge half-cycle stage.
module mfd_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run_q,
  input  logic             run_d,
  input  logic             mode_q,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_d,
  output logic             wrap,
  output logic             mclk
);

  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [HW-1:0]    half_d;
  logic             p_q, p_d;
  logic             n_q;
  logic             ratio_one, ratio_odd, raw_clk;

  assign wrap = run_q && (cnt_q == div_q);

  always_comb begin
    if (start || !run_q || wrap) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
    // high phase length in reference cycles: ceil((div+1)/2)
    half_d = ({1'b0, div_d} + HW'(2)) >> 1;
    p_d    = run_d && ({1'b0, cnt_d} < half_d);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      p_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      p_q   <= p_d;
    end
  end

  // Half-cycle delayed copy; changes only while the reference is low
  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) n_q <= 1'b0;
    else        n_q <= p_q;
  end

  assign ratio_one = (div_q == '0);
  assign ratio_odd = ~div_q[0];

  always_comb begin
    if (ratio_one)      raw_clk = clk_ref & n_q;
    else if (ratio_odd) raw_clk = p_q & n_q;
    else                raw_clk = p_q;
  end

  assign mclk = mode_q & raw_clk;

endmodule

// File: rtl/mfd_frame.sv
// Sample-rate strobe: one pulse every SLOTS*(fs+1) reference cycles.
module mfd_frame #(
  parameter int FS_W   = 6,
  parameter int SLOT_W = 5
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run_q,
  input  logic [FS_W-1:0] fs_q,
  output logic            frame_tick
);

  localparam int CNT_W = FS_W + SLOT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;
  logic             at_last;

  assign last_cnt = {fs_q, {SLOT_W{1'b1}}};
  assign at_last  = run_q && (cnt_q == last_cnt);

  always_comb begin
    if (start || !run_q || at_last) cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      frame_tick <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      frame_tick <= at_last;
    end
  end

endmodule

// File: rtl/mclk_frame_div.sv
module mclk_frame_div #(
  parameter int DIV_W = 6,
  parameter int FS_W  = 6,
  parameter int SLOTS = 32
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_in,
  input  logic [FS_W-1:0]  fs_in,
  input  logic             mode_in,
  input  logic             en_cmd,
  input  logic             dis_cmd,
  output logic             mclk,
  output logic             mclk_on,
  output logic             frame_tick
);

  localparam int SLOT_W = $clog2(SLOTS);

  logic             rst_meta, rst_s;
  logic             start, run_q, run_d, wrap, mode_q;
  logic [DIV_W-1:0] div_q, div_d;
  logic [FS_W-1:0]  fs_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  mfd_seq #(.DIV_W(DIV_W), .FS_W(FS_W)) u_seq (
    .clk_ref (clk_ref),
    .rst_n   (rst_s),
    .en_cmd  (en_cmd),
    .dis_cmd (dis_cmd),
    .wrap    (wrap),
    .div_in  (div_in),
    .fs_in   (fs_in),
    .mode_in (mode_in),
    .start   (start),
    .run_q   (run_q),
    .run_d   (run_d),
    .div_q   (div_q),
    .div_d   (div_d),
    .fs_q    (fs_q),
    .mode_q  (mode_q)
  );

  mfd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_ref (clk_ref),
    .rst_n   (rst_s),
    .start   (start),
    .run_q   (run_q),
    .run_d   (run_d),
    .mode_q  (mode_q),
    .div_q   (div_q),
    .div_d   (div_d),
    .wrap    (wrap),
    .mclk    (mclk)
  );

  mfd_frame #(.FS_W(FS_W), .SLOT_W(SLOT_W)) u_frame (
    .clk_ref    (clk_ref),
    .rst_n      (rst_s),
    .start      (start),
    .run_q      (run_q),
    .fs_q       (fs_q),
    .frame_tick (frame_tick)
  );

  assign mclk_on = run_q;

endmodule

// File: rtl/mclk_frame_div_chk.sv
module mclk_frame_div_chk #(
  parameter int DIV_W  = 6,
  parameter int FS_W   = 6,
  parameter int SLOT_W = 5
) (
  input logic             clk_ref,
  input logic             rst_s,
  input logic             en_cmd,
  input logic             dis_cmd,
  input logic             mclk_on,
  input logic             frame_tick,
  input logic             wrap,
  input logic [DIV_W-1:0] div_q,
  input logic [FS_W-1:0]  fs_q
);

  localparam int GW = FS_W + SLOT_W + 1;

  logic [GW-1:0] gap_q;
  logic [GW-1:0] exp_gap;

  assign exp_gap = {1'b0, fs_q, {SLOT_W{1'b1}}} + 1'b1;

  // Cycles since start or since the previous strobe
  always_ff @(posedge clk_ref or negedge rst_s) begin
    if (!rst_s)          gap_q <= '0;
    else if (!mclk_on)   gap_q <= '0;
    else if (frame_tick) gap_q <= GW'(1);
    else                 gap_q <= gap_q + 1'b1;
  end

  // R5
  start_by_cmd_chk: assert property (@(posedge clk_ref) disable iff (!rst_s)
    $rose(mclk_on) |-> $past(en_cmd && !dis_cmd));

  // R6
  stop_at_wrap_chk: assert property (@(posedge clk_ref) disable iff (!rst_s)
    $fell(mclk_on) |-> $past(wrap));

  // R7
  cfg_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_s)
    (mclk_on && $past(mclk_on)) |-> ($stable(div_q) && $stable(fs_q)));

  // R2
  frame_gap_chk: assert property (@(posedge clk_ref) disable iff (!rst_s)
    frame_tick |-> (gap_q == exp_gap));

  // R6
  tick_needs_run_chk: assert property (@(posedge clk_ref) disable iff (!rst_s)
    frame_tick |-> $past(mclk_on));

endmodule

bind mclk_frame_div mclk_frame_div_chk #(
  .DIV_W(DIV_W), .FS_W(FS_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk_ref    (clk_ref),
  .rst_s      (rst_s),
  .en_cmd     (en_cmd),
  .dis_cmd    (dis_cmd),
  .mclk_on    (mclk_on),
  .frame_tick (frame_tick),
  .wrap       (wrap),
  .div_q      (div_q),
  .fs_q       (fs_q)
);

// File: tb/mclk_frame_div_test.sv
module mclk_frame_div_test;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [5:0] div_in;
  logic [5:0] fs_in;
  logic       mode_in;
  logic       en_cmd;
  logic       dis_cmd;
  logic       mclk;
  logic       mclk_on;
  logic       frame_tick;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #5 clk_ref = ~clk_ref;

  mclk_frame_div uut (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .div_in     (div_in),
    .fs_in      (fs_in),
    .mode_in    (mode_in),
    .en_cmd     (en_cmd),
    .dis_cmd    (dis_cmd),
    .mclk       (mclk),
    .mclk_on    (mclk_on),
    .frame_tick (frame_tick)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected master clock at half-cycle index h after the accepting edge
  function automatic logic exp_mclk(input int h, input int n, input int md, input int js);
    int r;
    if (md == 0) return 1'b0;
    if (n == 1) return (h % 2 == 0) && (h >= 2) && (h <= 2 * js);
    if (h >= 2 * js) return 1'b0;
    r = h % (2 * n);
    if (n % 2 == 0) return r < n;
    return (r >= 1) && (r <= n);
  endfunction

  function automatic string mclk_tag(input int n, input int md);
    if (md == 0) return "R4";
    if (n % 2 == 0) return "R1";
    return "R3";
  endfunction

  task automatic idle_check(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk_ref); #2;
      chk(tag, "mclk idle", mclk, 1'b0);
      chk(tag, "mclk_on idle", mclk_on, 1'b0);
      chk(tag, "frame_tick idle", frame_tick, 1'b0);
      #5;
    end
  endtask

  // Entered and left at 7 ns after a rising reference edge.
  task automatic run_case(input int dv, input int fs, input int md, input int d, input int poke);
    int n, m, js, len;
    n   = dv + 1;
    m   = 32 * (fs + 1);
    js  = ((d + n - 1) / n) * n;
    len = d + n + 3;
    div_in  = 6'(dv);
    fs_in   = 6'(fs);
    mode_in = md[0];
    en_cmd  = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(posedge clk_ref); #2;
      chk(mclk_tag(n, md), "mclk high half", mclk, exp_mclk(2 * i, n, md, js));
      chk((i < js) ? "R5" : "R6", "mclk_on", mclk_on, (i < js));
      chk("R2", "frame_tick", frame_tick, (i >= m) && (i % m == 0) && (i <= js));
      #5;
      chk((i < js) ? mclk_tag(n, md) : "R6", "mclk low half", mclk,
          exp_mclk(2 * i + 1, n, md, js));
      en_cmd  = 1'b0;
      dis_cmd = (i + 1 == d);
      if (poke > 0 && i == poke) begin
        // R7: new fields while running must not matter
        div_in  = ~6'(dv);
        fs_in   = ~6'(fs);
        mode_in = ~md[0];
      end
      if (poke > 0 && i == poke + 3) en_cmd = 1'b1; // R5: enable while running
    end
    dis_cmd = 1'b0;
    en_cmd  = 1'b0;
    idle_check(3, "R6");
  endtask

  initial begin
    rst_n   = 1'b0;
    div_in  = '0;
    fs_in   = '0;
    mode_in = 1'b0;
    en_cmd  = 1'b0;
    dis_cmd = 1'b0;
    // R9: outputs low during reset, even with fields set
    div_in  = 6'd3;
    mode_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_ref); #2;
      chk("R9", "mclk in reset", mclk, 1'b0);
      chk("R9", "mclk_on in reset", mclk_on, 1'b0);
      chk("R9", "frame_tick in reset", frame_tick, 1'b0);
      #5;
    end
    rst_n = 1'b1;
    idle_check(5, "R9");

    // R8: disable while idle has no effect
    dis_cmd = 1'b1;
    @(posedge clk_ref); #7;
    dis_cmd = 1'b0;
    idle_check(4, "R8");

    // R5: enable together with disable while idle does not start
    en_cmd  = 1'b1;
    dis_cmd = 1'b1;
    @(posedge clk_ref); #7;
    en_cmd  = 1'b0;
    dis_cmd = 1'b0;
    idle_check(6, "R5");

    // Sweep of ratios 1..8 with two frame sizes; disable offset walks the phases
    for (int dv = 0; dv < 8; dv++) begin
      for (int fs = 0; fs < 2; fs++) begin
        run_case(dv, fs, 1, 64 * (fs + 1) + 1 + (dv + fs) % 5, 0);
      end
    end

    // R6 boundaries: disable on the first edge and exactly on a period end
    run_case(3, 0, 1, 1, 0);
    run_case(2, 0, 1, 6, 0);
    run_case(0, 0, 1, 1, 0);

    // R7/R5: fields and enable poked while running
    run_case(5, 1, 1, 150, 10);
    run_case(2, 0, 0, 80, 20);

    // R4: output mode 0
    run_case(2, 0, 0, 70, 0);
    run_case(0, 1, 0, 70, 0);
    run_case(3, 0, 0, 40, 0);

    // Widest ratio and the two documented frame ratios
    run_case(63, 1, 1, 133, 0);
    run_case(7, 63, 1, 2 * 2048 + 2, 0);
    run_case(0, 47, 1, 2 * 1536 + 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    done = 1'b1;
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule